// File: doc/BRIEF.md
# Asymmetric-Width Dual-Port RAM

This block is a dual-port memory of 1024 bytes. Each of its two ports sees the storage at a different width. The narrow side is a 32-bit word port for a processor-side bus. It takes byte addresses and can both write and read. The wide side is a 256-bit read-only port for fabric logic. It addresses whole rows, and one address step moves to the next 256-bit row.

Each wide row holds eight consecutive narrow words. The word with the lowest byte address sits in the least significant lane. Software fills a row with eight 32-bit stores spaced four bytes apart. Fabric logic then fetches all eight words in one wide read. Both ports return read data two clock edges after the request. Each port has its own clock.

Top module: `asym_dpram`

## Requirements
- R1: After reset, `a_rdata` and `b_rdata` are both zero, and they stay zero until the first read on that port completes.
- R2: Narrow word at byte address `A` lives in wide row `A[9:5]`, lane `A[4:2]`, which is bits `[32*lane+31 : 32*lane]` of the row. A write to byte 0 lands in bits [31:0] of row 0, and a write to byte 4 lands in bits [63:32] of row 0.
- R3: Bits [1:0] of `a_addr` are ignored. Any byte address selects the word that encloses it.
- R4: `a_we[k]` enables writing byte k, which is bits `[8k+7:8k]` of the addressed word. Bytes whose enable is low keep their previous contents.
- R5: A wide read requested with `b_en` high at rising edge N shows on `b_rdata` after edge N+1. Between edge N and edge N+1, `b_rdata` still shows the previous result.
- R6: A narrow read requested with `a_en` high and `a_we` zero at edge N returns the addressed 32-bit lane on `a_rdata` after edge N+1.
- R7: `a_rdata` and `b_rdata` hold their last value while their port issues no read.
- R8: With `a_en` low, `a_we` and `a_wdata` have no effect on the storage.
- R9: All 256 narrow words are distinct locations. A full fill through port A reads back exactly through all 32 wide rows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Narrow port clock |
| rst_a_n | input | 1 | Narrow port reset, active low, asynchronous assert |
| a_en | input | 1 | Narrow port access enable |
| a_we | input | 4 | Byte write enables, bit k for byte k |
| a_addr | input | 10 | Byte address |
| a_wdata | input | 32 | Write data |
| a_rdata | output | 32 | Read data, two-edge latency |
| clk_b | input | 1 | Wide port clock |
| rst_b_n | input | 1 | Wide port reset, active low, asynchronous assert |
| b_en | input | 1 | Wide read enable |
| b_addr | input | 5 | Row address |
| b_rdata | output | 256 | Row read data, two-edge latency |

## Verification
The hardest case to reach from the ports is a mapping fault that sends words to the wrong lane or merges rows. A single write followed by a read of the same address cannot show it. The bench therefore fills all 256 words with values that encode their own index, and then reads every wide row back against a model that places each word by its byte address. Partial byte enables, misaligned addresses and disabled writes each target a word whose value is already known. Any stray change shows up in the following wide read.

// File: rtl/asym_dpram_pkg.sv
package asym_dpram_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned DEF_NARROW  = 32;
  localparam int unsigned DEF_RATIO   = 8;
  localparam int unsigned DEF_ROWS    = 32;
endpackage

// File: rtl/asym_dpram_addr_map.sv
module asym_dpram_addr_map #(
  parameter int unsigned RATIO = 8,
  parameter int unsigned OFS   = 2,
  parameter int unsigned LW    = 3,
  parameter int unsigned RW    = 5,
  localparam int unsigned AW   = OFS + LW + RW
) (
  input  logic [AW-1:0]    byte_addr,
  output logic [RW-1:0]    row,
  output logic [LW-1:0]    lane,
  output logic [RATIO-1:0] lane_oh
);
  assign row  = byte_addr[OFS+LW +: RW];
  assign lane = byte_addr[OFS +: LW];

  for (genvar g = 0; g < RATIO; g++) begin : g_dec
    assign lane_oh[g] = (lane == LW'(g));
  end
endmodule

// File: rtl/asym_dpram_lane_bank.sv
module asym_dpram_lane_bank #(
  parameter int unsigned DW    = 32,
  parameter int unsigned ROWS  = 32,
  localparam int unsigned NB   = DW / asym_dpram_pkg::BYTE_W,
  localparam int unsigned RW   = $clog2(ROWS)
) (
  input  logic          clk_a,
  input  logic          a_wr,
  input  logic          a_rd,
  input  logic [NB-1:0] a_be,
  input  logic [RW-1:0] a_row,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_q,
  input  logic          clk_b,
  input  logic          b_rd,
  input  logic [RW-1:0] b_row,
  output logic [DW-1:0] b_q
);
  localparam int unsigned BW = asym_dpram_pkg::BYTE_W;

  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk_a) begin
    if (a_wr) begin
      for (int k = 0; k < NB; k++) begin
        if (a_be[k]) mem[a_row][k*BW +: BW] <= a_wdata[k*BW +: BW];
      end
    end
  end

  always_ff @(posedge clk_a) begin
    if (a_rd) a_q <= mem[a_row];
  end

  always_ff @(posedge clk_b) begin
    if (b_rd) b_q <= mem[b_row];
  end
endmodule

// File: rtl/asym_dpram_rd_stage.sv
module asym_dpram_rd_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic         vld_q;
  logic [W-1:0] dout_d;
  logic         seen_q;

  always_comb begin
    dout_d = dout;
    if (vld_q) dout_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      dout   <= '0;
      seen_q <= 1'b0;
    end else begin
      vld_q <= req;
      if (vld_q) begin
        dout   <= dout_d;
        seen_q <= 1'b1;
      end
    end
  end

  // R7: output register moves only one edge after a request
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |=> $stable(dout));

  // R1: zero until the first completed read
  a_r1_zero_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (dout == '0));
endmodule

// File: rtl/asym_dpram.sv
module asym_dpram #(
  parameter int unsigned NARROW = asym_dpram_pkg::DEF_NARROW,
  parameter int unsigned RATIO  = asym_dpram_pkg::DEF_RATIO,
  parameter int unsigned ROWS   = asym_dpram_pkg::DEF_ROWS,
  localparam int unsigned NB    = NARROW / asym_dpram_pkg::BYTE_W,
  localparam int unsigned OFS   = $clog2(NB),
  localparam int unsigned LW    = $clog2(RATIO),
  localparam int unsigned RW    = $clog2(ROWS),
  localparam int unsigned AW    = OFS + LW + RW,
  localparam int unsigned WIDE  = NARROW * RATIO
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              a_en,
  input  logic [NB-1:0]     a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [NARROW-1:0] a_wdata,
  output logic [NARROW-1:0] a_rdata,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic              b_en,
  input  logic [RW-1:0]     b_addr,
  output logic [WIDE-1:0]   b_rdata
);
  logic [RW-1:0]     a_row;
  logic [LW-1:0]     a_lane;
  logic [RATIO-1:0]  a_lane_oh;
  logic [RATIO-1:0]  lane_wr;
  logic              a_wr_any;
  logic              a_rd_req;
  logic [LW-1:0]     lane_q;
  logic [LW-1:0]     lane_d;
  logic [NARROW-1:0] a_q   [RATIO];
  logic [WIDE-1:0]   b_row_q;
  logic [NARROW-1:0] a_sel;

  asym_dpram_addr_map #(
    .RATIO(RATIO), .OFS(OFS), .LW(LW), .RW(RW)
  ) u_map (
    .byte_addr(a_addr),
    .row      (a_row),
    .lane     (a_lane),
    .lane_oh  (a_lane_oh)
  );

  assign a_wr_any = a_en && (a_we != '0);
  assign a_rd_req = a_en && (a_we == '0);
  assign lane_wr  = a_wr_any ? a_lane_oh : '0;

  for (genvar g = 0; g < RATIO; g++) begin : g_lane
    asym_dpram_lane_bank #(
      .DW(NARROW), .ROWS(ROWS)
    ) u_bank (
      .clk_a  (clk_a),
      .a_wr   (lane_wr[g]),
      .a_rd   (a_rd_req),
      .a_be   (a_we),
      .a_row  (a_row),
      .a_wdata(a_wdata),
      .a_q    (a_q[g]),
      .clk_b  (clk_b),
      .b_rd   (b_en),
      .b_row  (b_addr),
      .b_q    (b_row_q[g*NARROW +: NARROW])
    );
  end

  always_comb begin
    lane_d = lane_q;
    if (a_rd_req) lane_d = a_lane;
  end

  always_ff @(posedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n) lane_q <= '0;
    else          lane_q <= lane_d;
  end

  assign a_sel = a_q[lane_q];

  asym_dpram_rd_stage #(.W(NARROW)) u_a_out (
    .clk  (clk_a),
    .rst_n(rst_a_n),
    .req  (a_rd_req),
    .din  (a_sel),
    .dout (a_rdata)
  );

  asym_dpram_rd_stage #(.W(WIDE)) u_b_out (
    .clk  (clk_b),
    .rst_n(rst_b_n),
    .req  (b_en),
    .din  (b_row_q),
    .dout (b_rdata)
  );

  // R2: a write touches at most one lane of a row
  a_r2_one_lane: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    $onehot0(lane_wr));

  // R6: narrow read data changes only two edges after a read request
  a_r6_a_change_needs_req: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !$stable(a_rdata) |-> $past(a_rd_req, 2));
endmodule

// File: tb/asym_dpram_tb.sv
module asym_dpram_tb;
  logic         clk;
  logic         rst_n;
  logic         a_en;
  logic [3:0]   a_we;
  logic [9:0]   a_addr;
  logic [31:0]  a_wdata;
  logic [31:0]  a_rdata;
  logic         b_en;
  logic [4:0]   b_addr;
  logic [255:0] b_rdata;

  int n_chk;
  int n_bad;
  bit done;
  logic [31:0] ref_mem [256];

  asym_dpram u_dut (
    .clk_a(clk), .rst_a_n(rst_n), .a_en(a_en), .a_we(a_we),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .clk_b(clk), .rst_b_n(rst_n), .b_en(b_en), .b_addr(b_addr),
    .b_rdata(b_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [255:0] exp_row(input int r);
    logic [255:0] v;
    for (int l = 0; l < 8; l++) v[l*32 +: 32] = ref_mem[r*8 + l];
    return v;
  endfunction

  task automatic wr(input logic [9:0] addr, input logic [3:0] be,
                    input logic [31:0] data, input logic en);
    @(negedge clk);
    a_en = en; a_we = be; a_addr = addr; a_wdata = data;
    @(negedge clk);
    a_en = 1'b0; a_we = 4'h0;
    if (en) begin
      for (int k = 0; k < 4; k++)
        if (be[k]) ref_mem[addr[9:2]][k*8 +: 8] = data[k*8 +: 8];
    end
  endtask

  task automatic rd_b(input logic [4:0] row, output logic [255:0] v);
    @(negedge clk);
    b_en = 1'b1; b_addr = row;
    @(negedge clk);
    b_en = 1'b0;
    @(negedge clk);
    v = b_rdata;
  endtask

  task automatic rd_a(input logic [9:0] addr, output logic [31:0] v);
    @(negedge clk);
    a_en = 1'b1; a_we = 4'h0; a_addr = addr;
    @(negedge clk);
    a_en = 1'b0;
    @(negedge clk);
    v = a_rdata;
  endtask

  task automatic t_reset;
    chk("R1 a_rdata after reset", 256'(a_rdata), '0);
    chk("R1 b_rdata after reset", b_rdata, '0);
  endtask

  task automatic t_fill;
    logic [255:0] v;
    for (int i = 0; i < 256; i++)
      wr(10'(i*4), 4'hF, {8'(i), 8'(~i), 8'(i ^ 8'h5A), 8'(i + 3)}, 1'b1);
    for (int r = 0; r < 32; r++) begin
      rd_b(5'(r), v);
      chk("R9 full fill row readback", v, exp_row(r));
    end
  endtask

  task automatic t_lanes;
    logic [255:0] v;
    logic [31:0]  w;
    wr(10'd0, 4'hF, 32'hFFFF_FFFF, 1'b1);
    wr(10'd4, 4'hF, 32'hAAAA_AAAA, 1'b1);
    rd_b(5'd0, v);
    chk("R2 byte0 in [31:0]", 256'(v[31:0]), 256'(32'hFFFF_FFFF));
    chk("R2 byte4 in [63:32]", 256'(v[63:32]), 256'(32'hAAAA_AAAA));
    chk("R2 row0 whole", v, exp_row(0));
    wr(10'h3FC, 4'hF, 32'h1234_5678, 1'b1);
    rd_b(5'd31, v);
    chk("R2 last word in row31 lane7", 256'(v[255:224]), 256'(32'h1234_5678));
    rd_a(10'd4, w);
    chk("R6 narrow read lane1", 256'(w), 256'(32'hAAAA_AAAA));
    rd_a(10'h3FC, w);
    chk("R6 narrow read lane7 row31", 256'(w), 256'(32'h1234_5678));
  endtask

  task automatic t_low_bits;
    logic [255:0] v;
    logic [31:0]  w;
    wr(10'h08B, 4'hF, 32'hCAFE_0001, 1'b1);
    rd_a(10'h089, w);
    chk("R3 misaligned narrow read", 256'(w), 256'(32'hCAFE_0001));
    rd_b(5'd4, v);
    chk("R3 misaligned write lane2", v, exp_row(4));
  endtask

  task automatic t_byte_en;
    logic [31:0]  w;
    logic [255:0] v;
    wr(10'h100, 4'hF, 32'h1122_3344, 1'b1);
    wr(10'h100, 4'b0101, 32'hAABB_CCDD, 1'b1);
    rd_a(10'h100, w);
    chk("R4 bytes 0 and 2 only", 256'(w), 256'(32'h11BB_33DD));
    wr(10'h100, 4'b1000, 32'hEE00_0000, 1'b1);
    rd_b(5'd8, v);
    chk("R4 byte 3 only, wide view", v, exp_row(8));
  endtask

  task automatic t_disabled;
    logic [255:0] v;
    wr(10'h040, 4'hF, 32'hDEAD_BEEF, 1'b0);
    rd_b(5'd2, v);
    chk("R8 write with a_en low", v, exp_row(2));
  endtask

  task automatic t_latency;
    logic [255:0] old_v;
    logic [255:0] v;
    rd_b(5'd5, old_v);
    @(negedge clk);
    b_en = 1'b1; b_addr = 5'd6;
    @(negedge clk);
    b_en = 1'b0;
    chk("R5 old data one edge after request", b_rdata, old_v);
    @(negedge clk);
    chk("R5 new data two edges after request", b_rdata, exp_row(6));
    v = b_rdata;
    b_addr = 5'd9;
    repeat (3) @(negedge clk);
    chk("R7 wide output held without b_en", b_rdata, v);
  endtask

  task automatic t_hold_a;
    logic [31:0] w;
    rd_a(10'h010, w);
    a_addr = 10'h020;
    wr(10'h010, 4'hF, 32'h0BAD_F00D, 1'b1);
    repeat (2) @(negedge clk);
    chk("R7 narrow output held after write", 256'(a_rdata), 256'(w));
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    a_en = 1'b0; a_we = '0; a_addr = '0; a_wdata = '0;
    b_en = 1'b0; b_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_lanes();
    t_low_bits();
    t_byte_en();
    t_disabled();
    t_latency();
    t_hold_a();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule